// File: doc/BRIEF.md
# 256-bit Modular Add/Subtract/Multiply Unit

This block performs modular arithmetic on 256-bit operands for elliptic-curve work: addition, subtraction and multiplication. The modulus is chosen for each operation as either the curve field prime or the curve group order. A caller presents both operands, an opcode and a modulus select together with a one-cycle start pulse. Later it receives a one-cycle done pulse, and the reduced result sits on a registered output.

All three operations share a single 256-bit modular adder. Add and subtract each make one pass through it. Multiply walks the second operand from its top bit down. Every bit costs one doubling pass, and a set bit costs one further pass to add the first operand, so multiply latency follows the number of ones in that operand. Operands are assumed to be already reduced below the selected modulus. The unit accepts a new start only when idle.

Top module: `modarith_unit`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are 0 and `result` is 0 until the first operation completes.
- R2: With `op` = 0, the unit produces (A + B) mod m, and a sum equal to m yields 0; `done` rises on the first clock edge after the edge that samples `start`.
- R3: With `op` = 1, the unit produces (A − B) mod m, so A < B wraps to A − B + m; latency is the same as in R2.
- R4: With `op` = 2 or 3, the unit produces (A · B) mod m.
- R5: `mod_sel` = 0 selects the field prime 2^256 − 2^32 − 977, and `mod_sel` = 1 selects the group order; the selection is taken when `start` is accepted, and every result is below that modulus.
- R6: A multiply raises `done` exactly W + popcount(B) clock edges after the edge that samples `start`, where W = 256.
- R7: `done` lasts one cycle. `busy` is high from the cycle after acceptance through the last working cycle and is low whenever `done` is high.
- R8: A `start` pulse while `busy` is high is ignored: the running operation's result and latency are unchanged and no extra `done` follows.
- R9: `result` changes only together with `done` and holds its value while input pins change between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse, taken only when idle |
| op | input | 2 | 0 add, 1 subtract, 2 or 3 multiply |
| mod_sel | input | 1 | 0 field prime, 1 group order |
| opa | input | 256 | Operand A, already reduced |
| opb | input | 256 | Operand B, already reduced |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Registered result, held until the next completion |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a long multiply. To get there, the stimulus launches a multiply, waits a few cycles, and then pulses `start` with a different opcode and different operands. It checks that the multiply's latency and product are unchanged. Seeded random operands, reduced below each modulus, exercise the carry and borrow corrections. Directed values cover the edges: a sum exactly equal to the modulus, a subtraction that wraps, a zero multiplier with minimum latency, and a multiplier of m − 1.

// File: rtl/modarith_pkg.sv
package modarith_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_MUL_ALT = 2'd3
  } op_e;

  // operand routing into the shared adder
  typedef enum logic [1:0] {
    RT_AB_ADD = 2'd0,
    RT_AB_SUB = 2'd1,
    RT_DOUBLE = 2'd2,
    RT_ACC_A  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LINEAR = 2'd1,
    ST_DOUBLE = 2'd2,
    ST_ADDA   = 2'd3
  } state_e;

endpackage

// File: rtl/modarith_addsub.sv
module modarith_addsub #(
  parameter int W = 256
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] m,
  input  logic         sub,
  output logic [W-1:0] z
);

  logic [W:0] raw;
  logic [W:0] fix;

  always_comb begin
    if (sub) begin
      raw = {1'b0, x} - {1'b0, y};
      fix = raw + {1'b0, m};
      z   = raw[W] ? fix[W-1:0] : raw[W-1:0];
    end else begin
      raw = {1'b0, x} + {1'b0, y};
      fix = raw - {1'b0, m};
      z   = fix[W] ? raw[W-1:0] : fix[W-1:0];
    end
  end

endmodule

// File: rtl/modarith_seq.sv
module modarith_seq
  import modarith_pkg::*;
#(
  parameter int W  = 256,
  localparam int IW = $clog2(W)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic [1:0] op,
  input  logic   bbit,
  output logic [IW-1:0] bit_idx,
  output logic   accept,
  output logic   step,
  output logic   last,
  output route_e route,
  output logic   busy
);

  state_e  state_q, state_d;
  logic    is_sub_q;
  logic [IW-1:0] idx_q, idx_d;
  logic    idx_zero;

  assign bit_idx  = idx_q;
  assign idx_zero = (idx_q == '0);
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    accept  = 1'b0;
    step    = 1'b0;
    last    = 1'b0;
    route   = RT_AB_ADD;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          idx_d   = IW'(W - 1);
          state_d = (op[1]) ? ST_DOUBLE : ST_LINEAR;
        end
      end
      ST_LINEAR: begin
        route   = is_sub_q ? RT_AB_SUB : RT_AB_ADD;
        step    = 1'b1;
        last    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_DOUBLE: begin
        route = RT_DOUBLE;
        step  = 1'b1;
        if (bbit) begin
          state_d = ST_ADDA;
        end else if (idx_zero) begin
          last    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end
      ST_ADDA: begin
        route = RT_ACC_A;
        step  = 1'b1;
        if (idx_zero) begin
          last    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          idx_d   = idx_q - 1'b1;
          state_d = ST_DOUBLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      is_sub_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (accept) is_sub_q <= (op == OP_SUB);
    end
  end

endmodule

// File: rtl/modarith_unit.sv
module modarith_unit
  import modarith_pkg::*;
#(
  parameter int W = 256,
  parameter logic [W-1:0] P = 256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F,
  parameter logic [W-1:0] N = 256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_BAAEDCE6_AF48A03B_BFD25E8C_D0364141
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic         mod_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int IW = $clog2(W);

  logic [W-1:0] a_q, b_q, acc_q, mod_q;
  logic [W-1:0] ax, ay, sum;
  logic         asub;
  logic [IW-1:0] bit_idx;
  logic         accept, step, last, bbit;
  route_e       route;

  assign bbit = b_q[bit_idx];

  modarith_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .bbit    (bbit),
    .bit_idx (bit_idx),
    .accept  (accept),
    .step    (step),
    .last    (last),
    .route   (route),
    .busy    (busy)
  );

  always_comb begin
    ax   = a_q;
    ay   = b_q;
    asub = 1'b0;
    unique case (route)
      RT_AB_ADD: begin ax = a_q;   ay = b_q; end
      RT_AB_SUB: begin ax = a_q;   ay = b_q; asub = 1'b1; end
      RT_DOUBLE: begin ax = acc_q; ay = acc_q; end
      RT_ACC_A:  begin ax = acc_q; ay = a_q; end
      default:   begin ax = a_q;   ay = b_q; end
    endcase
  end

  modarith_addsub #(.W(W)) u_add (
    .x   (ax),
    .y   (ay),
    .m   (mod_q),
    .sub (asub),
    .z   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      mod_q  <= P;
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        a_q   <= opa;
        b_q   <= opb;
        mod_q <= mod_sel ? N : P;
        acc_q <= '0;
      end else if (step) begin
        acc_q <= sum;
      end
      if (last) result <= sum;
    end
  end

endmodule

// File: rtl/modarith_unit_chk.sv
module modarith_unit_chk #(
  parameter int W = 256,
  parameter logic [W-1:0] P = '0,
  parameter logic [W-1:0] N = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic         mod_sel,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);

  logic sel_seen;

  always_ff @(posedge clk) begin
    if (rst) sel_seen <= 1'b0;
    else if (start && !busy) sel_seen <= mod_sel;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_LINEAR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !op[1]) |=> (busy ##1 done)); // R2
  AST_BELOW_MODULUS: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < (sel_seen ? N : P))); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(result)); // R9
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !busy && !$past(rst)) |-> done); // R8

endmodule

bind modarith_unit modarith_unit_chk #(.W(W), .P(P), .N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .op      (op),
  .mod_sel (mod_sel),
  .busy    (busy),
  .done    (done),
  .result  (result)
);

// File: tb/modarith_unit_test.sv
`timescale 1ns/1ps
module modarith_unit_test;

  localparam int W = 256;
  localparam logic [W-1:0] PF = 256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;
  localparam logic [W-1:0] NF = 256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_BAAEDCE6_AF48A03B_BFD25E8C_D0364141;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic mod_sel = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic busy, done;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  modarith_unit uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .mod_sel(mod_sel),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] modv(input logic s);
    return s ? NF : PF;
  endfunction

  function automatic logic [W-1:0] ref_op(input logic [1:0] o, input logic s,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] m2, t;
    m2 = {{W{1'b0}}, modv(s)};
    if (o == 2'd0)      t = ({{W{1'b0}}, a} + {{W{1'b0}}, b}) % m2;
    else if (o == 2'd1) t = ({{W{1'b0}}, a} + m2 - {{W{1'b0}}, b}) % m2;
    else                t = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) % m2;
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // launch and wait; cycles = edges from sampling edge to done
  task automatic run_op(input logic [1:0] o, input logic s,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input int intrude_at,
                        output logic [W-1:0] res, output int cycles);
    @(negedge clk);
    op = o; mod_sel = s; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 2000) begin
      if (intrude_at > 0 && cycles == intrude_at) begin
        op = 2'd0; opa = 256'h5; opb = 256'h7; mod_sel = ~s; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: operation never completed actual=0 expected=1");
    end
    res = result;
  endtask

  task automatic test_one(input logic [1:0] o, input logic s,
                          input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W-1:0] r, e;
    int cyc, ecyc;
    e = ref_op(o, s, a, b);
    ecyc = o[1] ? W + $countones(b) : 1;
    run_op(o, s, a, b, 0, r, cyc);
    check(r == e, tag, r, e);
    check(cyc == ecyc, o[1] ? "R6 multiply latency" : "R2 linear latency",
          W'(cyc), W'(ecyc));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] r, a, b, held;
    int cyc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && result == '0, "R1 reset state", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && result == '0, "R1 after release", {busy, done}, '0);

    // directed corners
    test_one(2'd0, 1'b0, 256'd1, PF - 1, "R2 sum equal to modulus");
    test_one(2'd0, 1'b1, NF - 1, NF - 1, "R2 R5 add near group order");
    test_one(2'd1, 1'b0, 256'd0, 256'd1, "R3 wrap below zero");
    test_one(2'd1, 1'b1, 256'd9, 256'd4, "R3 R5 plain subtract");
    test_one(2'd2, 1'b0, PF - 1, 256'd0, "R4 zero multiplier");
    test_one(2'd3, 1'b1, NF - 1, NF - 1, "R4 R5 opcode 3 square of n-1");
    test_one(2'd2, 1'b0, PF - 1, PF - 1, "R4 square of p-1");

    // R8 start while busy ignored
    a = rnd256() % PF; b = rnd256() % PF;
    run_op(2'd2, 1'b0, a, b, 5, r, cyc);
    check(r == ref_op(2'd2, 1'b0, a, b), "R8 result unaffected", r, ref_op(2'd2, 1'b0, a, b));
    check(cyc == W + $countones(b), "R8 latency unaffected", W'(cyc), W'(W + $countones(b)));
    @(negedge clk);
    check(!done, "R8 no extra done", W'(done), '0);
    check(!busy, "R8 intruding start not queued", W'(busy), '0);

    // R9 hold
    held = result;
    opa = rnd256(); opb = rnd256(); op = 2'd1; mod_sel = 1'b1;
    repeat (4) @(negedge clk);
    check(result == held && !done, "R9 result held", result, held);

    // seeded random
    for (int i = 0; i < 24; i++) begin
      logic s;
      logic [1:0] o;
      s = 1'($urandom);
      o = 2'($urandom);
      a = rnd256() % modv(s);
      b = rnd256() % modv(s);
      test_one(o, s, a, b, o[1] ? "R4 random multiply" : (o[0] ? "R3 random subtract" : "R2 random add"));
    end

    // R7 done one cycle wide
    a = rnd256() % NF;
    run_op(2'd0, 1'b1, a, a, 0, r, cyc);
    check(done && !busy, "R7 done with busy low", {busy, done}, 256'd1);
    @(negedge clk);
    check(!done, "R7 done single cycle", W'(done), '0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule